// File: doc/BRIEF.md
# Trigger Input Qualifier and Timestamper

This block sits between a digital trigger line and the capture logic of a vision controller. The trigger arrives asynchronously, already converted to a clean logic level by an external comparator stage. The block resynchronises it and rejects short disturbances whose synchronised width is below a programmable window. A surviving pulse produces one output pulse of programmable, guaranteed width. That width does not depend on how long the input stayed high.

Each accepted trigger is stamped from a free-running cycle counter. The stamp and the gap since the previous accepted trigger are held in readout registers, and both update on the same clock edge. Software can build interval jitter statistics from these values. Two saturating counters show how the line misbehaves. One counts pulses thrown away as too short. The other counts rising edges that arrived while an output pulse was still being held and were therefore dropped. Each counter has its own write-one-to-clear strobe.

Top module: `trq_top`

## Requirements
- R1: A synchronised input pulse high for fewer clock cycles than the effective window W = max(cfg_window,1) produces no output pulse and no event, and adds one to glitch_count when it falls.
- R2: A synchronised input pulse high for at least W cycles produces exactly one output pulse and exactly one evt_valid pulse, however long it stays high.
- R3: The input passes two synchroniser flops. When trig_raw rises and is sampled at clock edge E0 and held, trig_out is first high after edge E(W+1), for every input pattern.
- R4: Every output pulse stays high for exactly max(cfg_stretch,1) cycles, whether the input pulse is shorter or longer than that.
- R5: A synchronised rising edge that arrives while trig_out is high adds one to miss_count. That input pulse is then ignored: it causes no new output, no event and no glitch count.
- R6: evt_valid is high for one cycle, in the first cycle trig_out is high. From that cycle on, last_stamp holds the free-running counter value of the accepting cycle.
- R7: last_interval changes only together with evt_valid. It equals the difference between the current and previous stamps, which is the number of cycles between the two evt_valid pulses. It is 0 for the first accepted trigger after reset.
- R8: glitch_count and miss_count stop at their all-ones value. Apart from a clear, they never decrease and never step by more than one.
- R9: A one-cycle pulse on clr_glitch sets glitch_count to 0, and a pulse on clr_miss sets miss_count to 0. Each clear leaves the other counter unchanged. A clear wins over an increment in the same cycle.
- R10: After reset, trig_out, evt_valid, last_stamp, last_interval and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | 1 | Asynchronous trigger level, active high |
| cfg_window | input | FW | Minimum accepted pulse width in cycles (0 acts as 1) |
| cfg_stretch | input | SW | Output pulse width in cycles (0 acts as 1) |
| clr_glitch | input | 1 | Write-one-to-clear strobe for glitch_count |
| clr_miss | input | 1 | Write-one-to-clear strobe for miss_count |
| trig_out | output | 1 | Qualified, stretched trigger |
| evt_valid | output | 1 | One-cycle marker of an accepted trigger |
| last_stamp | output | TW | Counter value of the latest accepted trigger |
| last_interval | output | TW | Cycles between the latest two accepted triggers |
| glitch_count | output | CW | Saturating count of rejected short pulses |
| miss_count | output | CW | Saturating count of edges dropped during an output pulse |

## Verification
The assertions assume that cfg_window and cfg_stretch stay constant while a pulse is being qualified or stretched. The output-width property compares against the stretch setting that applies at the falling edge. The stimulus therefore reprograms both values only after the line has been idle for longer than the largest window plus the largest stretch. Clear strobes are raised only on an idle line. The random pulse widths go from one cycle up to well past the window, so the boundary lengths W-1 and W occur again and again. The dropped-edge case and the saturation case are driven as directed sequences.

// File: rtl/trq_pkg.sv
package trq_pkg;

    // Single-cycle decisions made by the qualifier
    typedef struct packed {
        logic accept;   // pulse met the window, start an output pulse
        logic glitch;   // pulse fell before the window was met
        logic miss;     // rising edge while the output was busy
    } trq_evt_t;

endpackage

// File: rtl/trq_sync.sv
module trq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/trq_filter.sv
module trq_filter
    import trq_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_in,
    input  logic          busy,
    input  logic [FW-1:0] cfg_window,
    output trq_evt_t      evt
);
    typedef struct packed {
        logic          prev;
        logic          armed;
        logic [FW-1:0] run;
    } state_t;

    state_t        st_d, st_q;
    logic [FW-1:0] win;

    always_comb begin
        win  = (cfg_window == '0) ? FW'(1) : cfg_window;
        st_d = st_q;
        evt  = '0;
        st_d.prev = s_in;
        if (s_in) begin
            if (!st_q.prev) begin
                if (busy) begin
                    evt.miss   = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.run   = '0;
                end else begin
                    st_d.armed = 1'b1;
                    st_d.run   = FW'(1);
                    if (st_d.run >= win) evt.accept = 1'b1;
                end
            end else if (st_q.armed) begin
                st_d.run = st_q.run + FW'(1);
                if (st_d.run >= win) evt.accept = 1'b1;
            end
        end else begin
            if (st_q.prev && st_q.armed) evt.glitch = 1'b1;
            st_d.armed = 1'b0;
            st_d.run   = '0;
        end
        if (evt.accept) begin
            st_d.armed = 1'b0;
            st_d.run   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trq_stretch.sv
module trq_stretch #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [SW-1:0] cfg_stretch,
    output logic          pulse
);
    typedef struct packed {
        logic [SW-1:0] left;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept)
            st_d.left = (cfg_stretch == '0) ? SW'(1) : cfg_stretch;
        else if (st_q.left != '0)
            st_d.left = st_q.left - SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = (st_q.left != '0);
endmodule

// File: rtl/trq_stamp.sv
module trq_stamp #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    output logic          evt_valid,
    output logic [TW-1:0] stamp,
    output logic [TW-1:0] interval
);
    typedef struct packed {
        logic [TW-1:0] now;
        logic [TW-1:0] stamp;
        logic [TW-1:0] ival;
        logic          seen;
        logic          evt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.now = st_q.now + TW'(1);
        st_d.evt = accept;
        if (accept) begin
            st_d.stamp = st_q.now;
            st_d.ival  = st_q.seen ? (st_q.now - st_q.stamp) : '0;
            st_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_valid = st_q.evt;
    assign stamp     = st_q.stamp;
    assign interval  = st_q.ival;
endmodule

// File: rtl/trq_satcnt.sv
module trq_satcnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL = '1;

    typedef struct packed {
        logic [CW-1:0] val;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.val = '0;
        else if (inc && (st_q.val != FULL))
            st_d.val = st_q.val + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.val;
endmodule

// File: rtl/trq_top.sv
module trq_top
    import trq_pkg::*;
#(
    parameter int FW = 8,
    parameter int SW = 8,
    parameter int TW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_raw,
    input  logic [FW-1:0] cfg_window,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          clr_glitch,
    input  logic          clr_miss,
    output logic          trig_out,
    output logic          evt_valid,
    output logic [TW-1:0] last_stamp,
    output logic [TW-1:0] last_interval,
    output logic [CW-1:0] glitch_count,
    output logic [CW-1:0] miss_count
);
    localparam int NCNT = 2;

    logic          trig_s;
    trq_evt_t      evt;
    logic [NCNT-1:0] inc_v, clr_v;
    logic [CW-1:0] cnt_v [NCNT];

    trq_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(trig_raw), .q_out(trig_s)
    );

    trq_filter #(.FW(FW)) u_filter (
        .clk(clk), .rst_n(rst_n), .s_in(trig_s), .busy(trig_out),
        .cfg_window(cfg_window), .evt(evt)
    );

    trq_stretch #(.SW(SW)) u_stretch (
        .clk(clk), .rst_n(rst_n), .accept(evt.accept),
        .cfg_stretch(cfg_stretch), .pulse(trig_out)
    );

    trq_stamp #(.TW(TW)) u_stamp (
        .clk(clk), .rst_n(rst_n), .accept(evt.accept),
        .evt_valid(evt_valid), .stamp(last_stamp), .interval(last_interval)
    );

    assign inc_v = {evt.miss, evt.glitch};
    assign clr_v = {clr_miss, clr_glitch};

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        trq_satcnt #(.CW(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc_v[i]), .clr(clr_v[i]),
            .count(cnt_v[i])
        );
    end

    assign glitch_count = cnt_v[0];
    assign miss_count   = cnt_v[1];
endmodule

// File: rtl/trq_checker.sv
module trq_checker #(
    parameter int FW = 8,
    parameter int SW = 8,
    parameter int TW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] cfg_stretch,
    input logic          clr_glitch,
    input logic          clr_miss,
    input logic          trig_out,
    input logic          evt_valid,
    input logic [TW-1:0] last_interval,
    input logic [CW-1:0] glitch_count,
    input logic [CW-1:0] miss_count
);
    logic          was_out_q;
    logic [SW-1:0] high_q;
    logic [SW-1:0] eff_w;

    assign eff_w = (cfg_stretch == '0) ? SW'(1) : cfg_stretch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_out_q <= 1'b0;
            high_q    <= '0;
        end else begin
            was_out_q <= trig_out;
            high_q    <= trig_out ? high_q + SW'(1) : '0;
        end
    end

    AST_OUT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (was_out_q && !trig_out) |-> (high_q == eff_w)); // R4

    AST_EVT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (trig_out && !$past(trig_out))); // R6

    AST_IVAL_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_interval) |-> evt_valid); // R7

    AST_GLITCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_glitch) |-> ((glitch_count >= $past(glitch_count)) &&
                                (glitch_count - $past(glitch_count) <= CW'(1)))); // R8

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_miss) |-> ((miss_count >= $past(miss_count)) &&
                              (miss_count - $past(miss_count) <= CW'(1)))); // R8

    AST_MISS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_count != $past(miss_count)) && !$past(clr_miss)) |-> $past(trig_out)); // R5

    AST_GLITCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_glitch) |-> (glitch_count == '0)); // R9
endmodule

bind trq_top trq_checker #(.FW(FW), .SW(SW), .TW(TW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_stretch(cfg_stretch),
    .clr_glitch(clr_glitch), .clr_miss(clr_miss), .trig_out(trig_out),
    .evt_valid(evt_valid), .last_interval(last_interval),
    .glitch_count(glitch_count), .miss_count(miss_count)
);

// File: tb/tb_trq_top.sv
module tb_trq_top;
    localparam int FW = 8, SW = 8, TW = 32, CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_raw = 1'b0;
    logic [FW-1:0] cfg_window = 8'd1;
    logic [SW-1:0] cfg_stretch = 8'd1;
    logic          clr_glitch = 1'b0, clr_miss = 1'b0;
    logic          trig_out, evt_valid;
    logic [TW-1:0] last_stamp, last_interval;
    logic [CW-1:0] glitch_count, miss_count;

    int  total = 0, bad = 0;
    longint gcyc = 0;
    int  lat, width, nevt;
    longint ecyc;
    logic [TW-1:0] cap_stamp, cap_ival;
    logic   have_prev = 1'b0;
    longint prev_ecyc = 0;
    logic [TW-1:0] prev_stamp = '0;
    int  exp_gl = 0, exp_ms = 0;

    trq_top #(.FW(FW), .SW(SW), .TW(TW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw),
        .cfg_window(cfg_window), .cfg_stretch(cfg_stretch),
        .clr_glitch(clr_glitch), .clr_miss(clr_miss),
        .trig_out(trig_out), .evt_valid(evt_valid),
        .last_stamp(last_stamp), .last_interval(last_interval),
        .glitch_count(glitch_count), .miss_count(miss_count)
    );

    always #5 clk = ~clk;
    always @(posedge clk) gcyc <= gcyc + 1;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int sat(input int v);
        return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Drive pat[i] at negedge i, observe outputs at every negedge
    task automatic play(input logic [31:0] pat, input int n);
        lat = 0; width = 0; nevt = 0;
        for (int i = 0; i < n + 300; i++) begin
            @(negedge clk);
            if (trig_out && lat == 0 && width == 0) lat = i;
            if (trig_out) width++;
            if (evt_valid) begin
                nevt++;
                ecyc = gcyc;
                cap_stamp = last_stamp;
                cap_ival  = last_interval;
            end
            trig_raw = (i < n) ? pat[i] : 1'b0;
        end
    endtask

    task automatic check_event(input string req);
        if (!have_prev) begin
            check(cap_ival == 0, "R7", cap_ival, 0);
        end else begin
            check(cap_ival == TW'(ecyc - prev_ecyc), "R7", cap_ival, ecyc - prev_ecyc);
            check(cap_stamp - prev_stamp == cap_ival, req, cap_stamp - prev_stamp, cap_ival);
        end
        have_prev  = 1'b1;
        prev_ecyc  = ecyc;
        prev_stamp = cap_stamp;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(trig_out == 0 && evt_valid == 0, "R10", trig_out, 0);
        check(last_stamp == 0 && last_interval == 0, "R10", last_stamp, 0);
        check(glitch_count == 0 && miss_count == 0, "R10", glitch_count, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Directed: first accepted trigger, R3 latency and R7 zero interval
        cfg_window = 8'd3; cfg_stretch = 8'd5;
        play(32'h0000_003F, 6);
        check(lat == 5, "R3", lat, 5);
        check(width == 5, "R4", width, 5);
        check(nevt == 1, "R2", nevt, 1);
        check_event("R6");

        // Directed: second rise while output active, R5
        cfg_window = 8'd1; cfg_stretch = 8'd20;
        play(32'h0000_00E7, 8);
        exp_ms = sat(exp_ms + 1);
        check(nevt == 1, "R5", nevt, 1);
        check(width == 20, "R5", width, 20);
        check(miss_count == CW'(exp_ms), "R5", miss_count, exp_ms);
        check(glitch_count == CW'(exp_gl), "R5", glitch_count, exp_gl);
        check_event("R6");

        // Directed: cfg zero behaves as one
        cfg_window = 8'd0; cfg_stretch = 8'd0;
        play(32'h0000_0001, 1);
        check(lat == 3, "R3", lat, 3);
        check(width == 1, "R4", width, 1);
        check_event("R6");

        // Random pulses around the window boundary
        for (int it = 0; it < 60; it++) begin
            int w, m, len;
            logic [31:0] pat;
            w   = 1 + int'($urandom % 6);
            m   = 1 + int'($urandom % 10);
            len = 1 + int'($urandom % 12);
            if (it % 4 == 0) len = (w > 1) ? w - 1 : 1;
            if (it % 4 == 1) len = w;
            cfg_window = FW'(w); cfg_stretch = SW'(m);
            pat = (32'h1 << len) - 32'h1;
            play(pat, len);
            if (len >= w) begin
                check(nevt == 1, "R2", nevt, 1);
                check(lat == w + 2, "R3", lat, w + 2);
                check(width == m, "R4", width, m);
                check_event("R6");
            end else begin
                exp_gl = sat(exp_gl + 1);
                check(nevt == 0 && width == 0, "R1", width, 0);
                check(glitch_count == CW'(exp_gl), "R1", glitch_count, exp_gl);
            end
            check(miss_count == CW'(exp_ms), "R5", miss_count, exp_ms);
        end

        // Saturation, R8
        cfg_window = 8'd4; cfg_stretch = 8'd2;
        for (int k = 0; k < 18; k++) begin
            play(32'h1, 1);
            exp_gl = sat(exp_gl + 1);
        end
        check(glitch_count == CW'((1 << CW) - 1), "R8", glitch_count, (1 << CW) - 1);

        // Write-one-to-clear, R9
        @(negedge clk); clr_glitch = 1'b1;
        @(negedge clk); clr_glitch = 1'b0;
        check(glitch_count == 0, "R9", glitch_count, 0);
        check(miss_count == CW'(exp_ms), "R9", miss_count, exp_ms);
        exp_gl = 0;
        @(negedge clk); clr_miss = 1'b1;
        @(negedge clk); clr_miss = 1'b0;
        check(miss_count == 0, "R9", miss_count, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule